// File: doc/BRIEF.md
# Power-Down Clock Output Stop Sequencer

This block sits between the configuration registers of a clock generator and its output drivers. It takes the raw, asynchronous, active-low power-down pin, brings it into the internal CPU clock domain, and then runs an ordered shutdown. First every CPU-domain clock output is parked low on a falling edge. Next the slow reference output is parked low, once its own level is low. Only then are the crystal oscillator and the VCO turned off. When the pin is released, the crystal is enabled first. After a settle count the VCO follows, and after a second count the outputs are released on a falling edge.

While running, each gated output enable follows its configuration enable bit. A disabled output is held low and does not toggle. Outputs marked as free running, such as the memory feedback clock, ignore their enable bit, so only power-down stops them. All gate values are registers, so downstream gating cells never see a combinational glitch.

Top module: `pd_stop_seq`

## Requirements
- R1: While `rst` is high, `out_gate` and `ref_gate` are 0 and `xtal_en` and `vco_en` are 1. After `rst` falls, `out_gate` takes the running value at the first falling clock edge.
- R2: While running, bit i of `out_gate` equals `out_en[i] | FREE_MASK[i]`, updated on the falling clock edge. By default `FREE_MASK` sets only the top bit, the free-running feedback output, so that output ignores its enable bit.
- R3: When `pd_n_async` goes low between two rising edges, `out_gate` still holds the running value at the falling edge after the second rising edge. From the falling edge after the third rising edge it is all zero. Changes of `out_en` have no effect while powered down.
- R4: `ref_gate` changes only at a rising edge where `ref_level` is sampled low. It then takes the value `ref_en` AND (block running).
- R5: `xtal_en` and `vco_en` fall together, and only after `out_gate` is all zero and `ref_gate` is 0. While `ref_level` stays high during shutdown, both stay high.
- R6: After `pd_n_async` rises, `xtal_en` is 1 from the third rising edge. `vco_en` rises `XTAL_SETTLE_CYC` edges later. `out_gate` is restored at the falling edge after a further `VCO_SETTLE_CYC` rising edges. The wake latency of 3 + `XTAL_SETTLE_CYC` + `VCO_SETTLE_CYC` cycles must be set within the 3 ms power-up budget.
- R7: A power-down request that reaches the sequencer during wake-up, including the edge at which wake-up would complete, takes priority. Both oscillator enables drop and `out_gate` stays zero.
- R8: Once a shutdown has begun, it runs through to oscillator-off even if the pin is released early. The block then wakes by itself.
- R9: `vco_en` is never 1 while `xtal_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n_async | input | 1 | Raw power-down pin, active low, asynchronous |
| out_en | input | N_OUT | Per-output enable bits from configuration |
| ref_en | input | 1 | Enable bit of the reference output |
| ref_level | input | 1 | Current level of the reference clock |
| out_gate | output | N_OUT | Gated enables for the CPU-domain outputs, falling-edge registered |
| ref_gate | output | 1 | Gated enable for the reference output |
| vco_en | output | 1 | VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
Wake-up completion and a fresh power-down request can land on the same rising edge. The bench arranges this by driving the pin low exactly three edges before the edge at which the wake counter expires. It then expects both enables low and no output released at the following falling edge, rather than a brief burst of clocks. A second collision is a reference that is still high when the outputs have been parked. The bench holds `ref_level` high across the shutdown and expects the oscillator enables to wait for the edge at which it drops.

// File: rtl/pd_seq_pkg.sv
`timescale 1ns/1ps
package pd_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN          = 3'd0,
    ST_STOP_OUTPUTS = 3'd1,
    ST_WAIT_REF_LOW = 3'd2,
    ST_OSC_OFF      = 3'd3,
    ST_WAKE         = 3'd4
  } seq_state_t;
endpackage

// File: rtl/pd_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for the raw power-down pin; resets to the idle (high) level.
module pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_async,
  output logic dout
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b1;
          else     stage_q[g] <= din_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b1;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pd_seq_fsm.sv
`timescale 1ns/1ps
// Shutdown / wake ordering: outputs, then reference, then oscillators; reverse on wake.
module pd_seq_fsm
  import pd_seq_pkg::*;
#(
  parameter int XTAL_SETTLE_CYC = 8,
  parameter int VCO_SETTLE_CYC  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_req,
  input  logic ref_level,
  input  logic ref_gate,
  output logic run_allow,
  output logic vco_en,
  output logic xtal_en
);
  localparam int WAKE_CYC = XTAL_SETTLE_CYC + VCO_SETTLE_CYC;
  localparam int CW       = $clog2(WAKE_CYC + 1);

  seq_state_t     state_q;
  logic [CW-1:0]  cnt_q;
  logic           vco_q;
  logic           xtal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      vco_q   <= 1'b1;
      xtal_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (pd_req) state_q <= ST_STOP_OUTPUTS;
        end
        ST_STOP_OUTPUTS: begin
          // falling edge inside this cycle parks the outputs
          state_q <= ST_WAIT_REF_LOW;
        end
        ST_WAIT_REF_LOW: begin
          if (!ref_level || !ref_gate) begin
            state_q <= ST_OSC_OFF;
            vco_q   <= 1'b0;
            xtal_q  <= 1'b0;
          end
        end
        ST_OSC_OFF: begin
          if (!pd_req) begin
            state_q <= ST_WAKE;
            xtal_q  <= 1'b1;
            cnt_q   <= '0;
          end
        end
        ST_WAKE: begin
          if (pd_req) begin
            state_q <= ST_OSC_OFF;
            vco_q   <= 1'b0;
            xtal_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == CW'(XTAL_SETTLE_CYC - 1)) vco_q <= 1'b1;
            if (cnt_q == CW'(WAKE_CYC - 1))        state_q <= ST_RUN;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign run_allow = (state_q == ST_RUN);
  assign vco_en    = vco_q;
  assign xtal_en   = xtal_q;
endmodule

// File: rtl/pd_out_gate.sv
`timescale 1ns/1ps
// Output gate registers: CPU-domain gates on the falling edge, reference gate only while the reference is low.
module pd_out_gate #(
  parameter int               N_OUT     = 8,
  parameter logic [N_OUT-1:0] FREE_MASK = {1'b1, {(N_OUT-1){1'b0}}}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_allow,
  input  logic [N_OUT-1:0] out_en,
  input  logic             ref_en,
  input  logic             ref_level,
  output logic [N_OUT-1:0] out_gate,
  output logic             ref_gate
);
  logic [N_OUT-1:0] want;
  logic             ref_want;

  always_comb begin
    want     = run_allow ? (out_en | FREE_MASK) : '0;
    ref_want = run_allow & ref_en;
  end

  always_ff @(negedge clk) begin
    if (rst) out_gate <= '0;
    else     out_gate <= want;
  end

  always_ff @(posedge clk) begin
    if (rst)             ref_gate <= 1'b0;
    else if (!ref_level) ref_gate <= ref_want;
  end
endmodule

// File: rtl/pd_stop_seq.sv
`timescale 1ns/1ps
module pd_stop_seq #(
  parameter int               N_OUT           = 8,
  parameter logic [N_OUT-1:0] FREE_MASK       = {1'b1, {(N_OUT-1){1'b0}}},
  parameter int               SYNC_STAGES     = 2,
  parameter int               XTAL_SETTLE_CYC = 8,
  parameter int               VCO_SETTLE_CYC  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_n_async,
  input  logic [N_OUT-1:0] out_en,
  input  logic             ref_en,
  input  logic             ref_level,
  output logic [N_OUT-1:0] out_gate,
  output logic             ref_gate,
  output logic             vco_en,
  output logic             xtal_en
);
  logic pd_n_sync;
  logic pd_req;
  logic run_allow;

  pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .din_async (pd_n_async),
    .dout      (pd_n_sync)
  );

  assign pd_req = ~pd_n_sync;

  pd_seq_fsm #(
    .XTAL_SETTLE_CYC (XTAL_SETTLE_CYC),
    .VCO_SETTLE_CYC  (VCO_SETTLE_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .pd_req    (pd_req),
    .ref_level (ref_level),
    .ref_gate  (ref_gate),
    .run_allow (run_allow),
    .vco_en    (vco_en),
    .xtal_en   (xtal_en)
  );

  pd_out_gate #(.N_OUT(N_OUT), .FREE_MASK(FREE_MASK)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .run_allow (run_allow),
    .out_en    (out_en),
    .ref_en    (ref_en),
    .ref_level (ref_level),
    .out_gate  (out_gate),
    .ref_gate  (ref_gate)
  );
endmodule

// File: rtl/pd_stop_seq_chk.sv
`timescale 1ns/1ps
module pd_stop_seq_chk #(
  parameter int N_OUT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_OUT-1:0] out_gate,
  input logic             ref_gate,
  input logic             ref_level,
  input logic             vco_en,
  input logic             xtal_en
);
  assert_parked_before_osc_off_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(vco_en) |-> (out_gate == '0 && !ref_gate));

  assert_gates_off_without_vco_R5: assert property (@(posedge clk) disable iff (rst)
    !vco_en |-> (out_gate == '0));

  assert_vco_after_xtal_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(vco_en) |-> $past(xtal_en));

  assert_vco_needs_xtal_R9: assert property (@(posedge clk) disable iff (rst)
    vco_en |-> xtal_en);

  assert_ref_moves_low_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(ref_gate) |-> !$past(ref_level));
endmodule

bind pd_stop_seq pd_stop_seq_chk #(.N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_gate  (out_gate),
  .ref_gate  (ref_gate),
  .ref_level (ref_level),
  .vco_en    (vco_en),
  .xtal_en   (xtal_en)
);

// File: tb/tb_pd_stop_seq.sv
`timescale 1ns/1ps
module tb_pd_stop_seq;
  localparam int              N   = 6;
  localparam logic [N-1:0]    FM  = 6'h20;
  localparam int              XT  = 3;
  localparam int              VC  = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         pd_n;
  logic [N-1:0] out_en;
  logic         ref_en;
  logic         ref_level;
  logic [N-1:0] out_gate;
  logic         ref_gate;
  logic         vco_en;
  logic         xtal_en;
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  pd_stop_seq #(
    .N_OUT(N), .FREE_MASK(FM), .SYNC_STAGES(2),
    .XTAL_SETTLE_CYC(XT), .VCO_SETTLE_CYC(VC)
  ) dut (
    .clk(clk), .rst(rst), .pd_n_async(pd_n), .out_en(out_en),
    .ref_en(ref_en), .ref_level(ref_level), .out_gate(out_gate),
    .ref_gate(ref_gate), .vco_en(vco_en), .xtal_en(xtal_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1.25;
  endtask

  task automatic fall();
    @(negedge clk); #1.25;
  endtask

  task automatic run_all();
    bit seen;
    rst = 1'b1; pd_n = 1'b1; out_en = 6'h15; ref_en = 1'b1; ref_level = 1'b0;
    repeat (4) step();
    fall();
    chk("R1 gate in reset", out_gate, 0);
    chk("R1 xtal in reset", xtal_en, 1);
    chk("R1 vco in reset", vco_en, 1);
    chk("R1 ref in reset", ref_gate, 0);
    step();
    rst = 1'b0;
    fall();
    chk("R1 gate after reset", out_gate, 6'h15 | FM);
    step();
    chk("R4 ref gate starts", ref_gate, 1);

    // R2 sweep of every enable pattern
    for (int v = 0; v < (1 << N); v++) begin
      out_en = v[N-1:0];
      fall();
      chk("R2 gate follows enables", out_gate, v[N-1:0] | FM);
      step();
    end

    // R4 reference gate only moves while reference is low
    ref_level = 1'b1; ref_en = 1'b0;
    step(); chk("R4 ref held while high", ref_gate, 1);
    step(); chk("R4 ref held while high", ref_gate, 1);
    ref_level = 1'b0;
    step(); chk("R4 ref parks when low", ref_gate, 0);
    ref_en = 1'b1;
    step(); chk("R4 ref restarts when low", ref_gate, 1);

    // R3 synchronizer latency, R5 wait for reference
    out_en = 6'h0A; ref_level = 1'b1;
    step();
    pd_n = 1'b0;
    fall(); chk("R3 running e0", out_gate, 6'h0A | FM);
    step(); fall(); chk("R3 running e1", out_gate, 6'h0A | FM);
    step(); fall(); chk("R3 running e2", out_gate, 6'h0A | FM);
    step(); fall(); chk("R3 parked e3", out_gate, 0);
    repeat (6) step();
    chk("R5 vco waits for ref", vco_en, 1);
    chk("R5 xtal waits for ref", xtal_en, 1);
    chk("R5 ref still gated", ref_gate, 1);
    ref_level = 1'b0;
    step();
    chk("R5 vco off", vco_en, 0);
    chk("R5 xtal off", xtal_en, 0);
    chk("R5 ref parked", ref_gate, 0);
    out_en = 6'h3F;
    fall(); chk("R3 enables ignored when down", out_gate, 0);

    // R6 wake order and latency
    step();
    pd_n = 1'b1;
    step(); chk("R6 xtal still off e1", xtal_en, 0);
    step(); chk("R6 xtal still off e2", xtal_en, 0);
    step(); chk("R6 xtal on e3", xtal_en, 1);
    chk("R6 vco off e3", vco_en, 0);
    for (int k = 1; k <= XT; k++) begin
      step(); chk("R6 vco timing", vco_en, (k == XT) ? 1 : 0);
    end
    for (int k = 1; k <= VC; k++) begin
      step(); fall();
      chk("R6 output release timing", out_gate, (k == VC) ? (6'h3F | FM) : 0);
    end
    step(); chk("R6 ref gate back", ref_gate, 1);

    // R7 power-down on the same edge that wake-up completes
    pd_n = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 20 && !seen; k++) begin
      step();
      if (!vco_en) seen = 1'b1;
    end
    chk("R7 entered osc off", seen, 1);
    pd_n = 1'b1;
    repeat (3) step();
    chk("R7 wake started", xtal_en, 1);
    repeat (XT + VC - 3) step();
    chk("R7 vco up before collision", vco_en, 1);
    pd_n = 1'b0;
    repeat (3) step();
    chk("R7 vco dropped", vco_en, 0);
    chk("R7 xtal dropped", xtal_en, 0);
    fall(); chk("R7 no output release", out_gate, 0);
    repeat (5) step();
    chk("R7 stays down", xtal_en, 0);
    pd_n = 1'b1;
    repeat (3 + XT + VC) step();
    fall(); chk("R6 restored after abort", out_gate, 6'h3F | FM);

    // R8 short pulse still completes the shutdown
    step();
    out_en = 6'h00;
    pd_n = 1'b0;
    step();
    pd_n = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 12 && !seen; k++) begin
      step();
      if (!vco_en) seen = 1'b1;
    end
    chk("R8 shutdown completed", seen, 1);
    repeat (3 + XT + VC + 2) step();
    chk("R8 vco back", vco_en, 1);
    chk("R9 xtal with vco", xtal_en, 1);
    fall(); chk("R8 free output back", out_gate, FM);
  endtask

  initial begin
    fork
      run_all();
      begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule